// File: doc/BRIEF.md
# Banked Program Counter Unit

This unit holds the program fetch address of a small 4-bit processor core. The 13-bit address is made of a 1-bit bank, a 4-bit page and an 8-bit step, which covers 8,192 words of 12 bits. Each instruction slot, the decoder presents one operation code together with the operands it needs. The operations are a sequential advance, a jump, a conditional jump, a call, a call to page zero, a return, a page preset and a forced interrupt vector. The unit then updates the address on the next clock edge.

A page-preset operation stores a bank and page. These are consumed only by a jump or call in the very next slot. Otherwise, branches replace only the step and stay in the current bank and page. For call-type operations the unit presents a 13-bit value to push, with a write strobe. Return loads a full 13-bit address from a return input. The return input and the push output stand in for an external stack.

Top module: `pc_unit`

## Requirements
- R1: While rst_n is low, addr_o is 0 and no page preset is pending.
- R2: With slot_i high and op_i=0 (advance), the step field addr_o[7:0] increments by one. It wraps from FFh to 00h and leaves bank addr_o[12] and page addr_o[11:8] unchanged.
- R3: op_i=6 (preset) stores pset_i, where bit 4 is the new bank and bits 3:0 are the new page. If the next slot is a jump (op_i=1) or a call (op_i=3), that operation goes to {pset bank, pset page, step_i}. For example, a preset of 13h followed by a jump to 08h gives 1308h.
- R4: A jump with no pending preset sets the step to step_i and keeps the current bank and page.
- R5: Any slot other than a preset clears the pending preset, so a later branch stays in the current page. Two back-to-back presets leave the second one pending.
- R6: op_i=2 (conditional jump) acts as a jump when cond_i is 1 and as an advance when cond_i is 0.
- R7: op_i=3 (call) goes to its target like a jump. In the same slot it raises push_en_o with push_o equal to the current bank and page and the step plus one, wrapping within the page.
- R8: op_i=4 (zero-page call) goes to bank unchanged, page 0, step step_i, ignoring any pending preset. It pushes the same value as R7.
- R9: op_i=5 (return) loads all 13 bits of ret_i into the address.
- R10: op_i=7 (interrupt) goes to the current bank, page 1, step vec_i. It pushes the current address unchanged with push_en_o high, and it ignores any pending preset.
- R11: With slot_i low, the address and the pending preset are unchanged and push_en_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Instruction slot strobe |
| op_i | input | 3 | Operation code (0 advance, 1 jump, 2 cond jump, 3 call, 4 zero-page call, 5 return, 6 preset, 7 interrupt) |
| cond_i | input | 1 | Condition for op 2 |
| step_i | input | 8 | Branch target step |
| pset_i | input | 5 | Preset operand: {bank, page} |
| vec_i | input | 4 | Interrupt vector step |
| ret_i | input | 13 | Return address from stack |
| addr_o | output | 13 | Fetch address {bank, page, step} |
| push_o | output | 13 | Value to push onto the stack |
| push_en_o | output | 1 | Push strobe |

## Verification
The bench uses the default parameters: a 1-bit bank, a 4-bit page, an 8-bit step, a 4-bit vector and page 1 for interrupts. With these values, the preset of 13h followed by a jump to 08h can be checked against the fixed result 1308h. A jump to step FFh followed by an advance brings the step wrap within reach in a few cycles, so no 256-cycle run is needed to see that the page does not carry.

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int BANK_W   = 1,
  parameter int PAGE_W   = 4,
  parameter int STEP_W   = 8,
  parameter int VEC_W    = 4,
  parameter int INT_PAGE = 1,
  localparam int ADDR_W  = BANK_W + PAGE_W + STEP_W,
  localparam int BP_W    = BANK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_i,
  input  logic [2:0]        op_i,
  input  logic              cond_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [BP_W-1:0]   pset_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] ret_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] push_o,
  output logic              push_en_o
);

  localparam logic [2:0] OP_SEQ  = 3'd0;
  localparam logic [2:0] OP_JP   = 3'd1;
  localparam logic [2:0] OP_JPC  = 3'd2;
  localparam logic [2:0] OP_CALL = 3'd3;
  localparam logic [2:0] OP_CALZ = 3'd4;
  localparam logic [2:0] OP_RET  = 3'd5;
  localparam logic [2:0] OP_PSET = 3'd6;
  localparam logic [2:0] OP_INT  = 3'd7;

  logic [BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] page_q;
  logic [STEP_W-1:0] step_q;
  logic [BP_W-1:0]   new_q;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_nxt;

  wire [STEP_W-1:0] step_inc = step_q + 1'b1;
  wire              far_br   = (op_i == OP_JP) || (op_i == OP_CALL) ||
                               (op_i == OP_JPC && cond_i);
  wire [BP_W-1:0]   dest_bp  = pend_q ? new_q : {bank_q, page_q};

  assign addr_o    = {bank_q, page_q, step_q};
  assign push_o    = (op_i == OP_INT) ? addr_o : {bank_q, page_q, step_inc};
  assign push_en_o = slot_i && (op_i == OP_CALL || op_i == OP_CALZ || op_i == OP_INT);

  always_comb begin
    if (far_br)
      addr_nxt = {dest_bp, step_i};
    else begin
      case (op_i)
        OP_CALZ: addr_nxt = {bank_q, {PAGE_W{1'b0}}, step_i};
        OP_RET:  addr_nxt = ret_i;
        OP_INT:  addr_nxt = {bank_q, PAGE_W'(INT_PAGE), STEP_W'(vec_i)};
        default: addr_nxt = {bank_q, page_q, step_inc};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      page_q <= '0;
      step_q <= '0;
      new_q  <= '0;
      pend_q <= 1'b0;
    end else if (slot_i) begin
      {bank_q, page_q, step_q} <= addr_nxt;
      pend_q <= (op_i == OP_PSET);
      if (op_i == OP_PSET) new_q <= pset_i;
    end
  end

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && op_i == OP_SEQ |=>
      addr_o[STEP_W-1:0] == $past(addr_o[STEP_W-1:0]) + 1'b1 &&
      addr_o[ADDR_W-1:STEP_W] == $past(addr_o[ADDR_W-1:STEP_W]));

  // R4
  near_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && op_i == OP_JP && !pend_q |=>
      addr_o == {$past(addr_o[ADDR_W-1:STEP_W]), $past(step_i)});

  // R8
  zero_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && op_i == OP_CALZ |=>
      addr_o[ADDR_W-1 -: BANK_W] == $past(addr_o[ADDR_W-1 -: BANK_W]) &&
      addr_o[STEP_W +: PAGE_W] == '0);

  // R9
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && op_i == OP_RET |=> addr_o == $past(ret_i));

  // R10
  int_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && op_i == OP_INT |=>
      addr_o[STEP_W +: PAGE_W] == PAGE_W'(INT_PAGE) &&
      addr_o[STEP_W-1:0] == STEP_W'($past(vec_i)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> $stable(addr_o));

endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        cond_i = 1'b0;
  logic [7:0]  step_i = '0;
  logic [4:0]  pset_i = '0;
  logic [3:0]  vec_i = '0;
  logic [12:0] ret_i = '0;
  logic [12:0] addr_o, push_o;
  logic        push_en_o;

  pc_unit u_dut (.clk(clk), .rst_n(rst_n), .slot_i(slot_i), .op_i(op_i),
    .cond_i(cond_i), .step_i(step_i), .pset_i(pset_i), .vec_i(vec_i),
    .ret_i(ret_i), .addr_o(addr_o), .push_o(push_o), .push_en_o(push_en_o));

  always #10 clk = ~clk;

  typedef struct { logic [12:0] exp; string tag; } item_t;
  item_t q[$];
  item_t it;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [12:0] m_addr;
  logic        m_pend;
  logic [4:0]  m_new;

  task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, addr_o, it.exp);
    end
  end

  task automatic do_op(string tag, logic [2:0] op, logic [7:0] st = 0,
                       logic c = 0, logic [4:0] ps = 0, logic [3:0] v = 0,
                       logic [12:0] r = 0, logic slot = 1);
    logic [12:0] nxt;
    logic [12:0] pexp;
    logic        pen;
    @(negedge clk);
    slot_i = slot; op_i = op; step_i = st; cond_i = c; pset_i = ps; vec_i = v; ret_i = r;
    pen  = slot && (op == 3 || op == 4 || op == 7);
    pexp = (op == 7) ? m_addr : {m_addr[12:8], m_addr[7:0] + 8'd1};
    nxt  = {m_addr[12:8], m_addr[7:0] + 8'd1};
    case (op)
      3'd1, 3'd3: nxt = {m_pend ? m_new : m_addr[12:8], st};
      3'd2: if (c) nxt = {m_pend ? m_new : m_addr[12:8], st};
      3'd4: nxt = {m_addr[12], 4'h0, st};
      3'd5: nxt = r;
      3'd7: nxt = {m_addr[12], 4'h1, 4'h0, v};
      default: ;
    endcase
    if (!slot) nxt = m_addr;
    #1;
    chk({tag, " push_en"}, {12'd0, push_en_o}, {12'd0, pen});
    if (pen) chk({tag, " push"}, push_o, pexp);
    @(posedge clk);
    #1;
    if (slot) begin
      m_addr = nxt;
      if (op == 6) m_new = ps;
      m_pend = (op == 6);
    end
    q.push_back('{exp: m_addr, tag: tag});
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_addr = '0; m_pend = 1'b0; m_new = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", addr_o, 13'h0000);
    rst_n = 1'b1;
    do_op("R2 advance", 0);
    do_op("R2 advance", 0);
    do_op("R4 near jump", 1, 8'hFE);
    do_op("R2 advance", 0);
    do_op("R2 step wrap", 0);
    do_op("R3 preset", 6, 0, 0, 5'h02);
    do_op("R3 far jump", 1, 8'hFF);
    do_op("R2 wrap no page carry", 0);
    do_op("R3 preset 13h", 6, 0, 0, 5'h13);
    do_op("R3 jump to 1308h", 1, 8'h08);
    chk("R3 fixed result", addr_o, 13'h1308);
    do_op("R5 preset", 6, 0, 0, 5'h05);
    do_op("R5 advance clears", 0);
    do_op("R5 jump stays in page", 1, 8'h40);
    do_op("R5 preset a", 6, 0, 0, 5'h07);
    do_op("R5 preset b", 6, 0, 0, 5'h02);
    do_op("R5 latest preset wins", 1, 8'h10);
    do_op("R6 cond not taken", 2, 8'h55, 0);
    do_op("R6 preset", 6, 0, 0, 5'h1A);
    do_op("R6 cond not taken clears", 2, 8'h66, 0);
    do_op("R5 jump after not-taken", 1, 8'h20);
    do_op("R6 cond taken", 2, 8'h30, 1);
    do_op("R7 preset", 6, 0, 0, 5'h14);
    do_op("R7 far call", 3, 8'h77);
    do_op("R7 near call", 3, 8'hFF);
    do_op("R7 call push wrap", 3, 8'h80);
    do_op("R8 preset", 6, 0, 0, 5'h03);
    do_op("R8 zero-page call", 4, 8'h12);
    do_op("R9 return", 5, 0, 0, 0, 0, 13'h0ABC);
    do_op("R10 preset", 6, 0, 0, 5'h1F);
    do_op("R10 interrupt", 7, 0, 0, 0, 4'h5);
    do_op("R5 jump after interrupt", 1, 8'h33);
    do_op("R9 return bank1", 5, 0, 0, 0, 0, 13'h1F00);
    do_op("R10 interrupt bank1", 7, 0, 0, 0, 4'hF);
    do_op("R11 preset", 6, 0, 0, 5'h09);
    do_op("R11 idle slot", 1, 8'h99, 0, 0, 0, 0, 0);
    do_op("R11 idle call", 3, 8'h44, 0, 0, 0, 0, 0);
    do_op("R11 preset kept", 1, 8'h21);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule